// File: doc/BRIEF.md
# Selectable Timing Pulse Generator

This block turns the sub-second prescaler of a real-time clock into a test pulse on an output pin. The pin can carry a 1024 Hz square wave for oscillator checks, or a slow pulse with a 10-second period for checking clock accuracy. A select bit chooses between the two. The select bit sits in a control register and is committed by a load strobe, which the serial interface raises at the 8th leading serial clock edge of the write access.

The slow pulse is built by counting whole-second ticks modulo 10. Each tick comes from the wrap of the prescaler. The pulse is low for the first six seconds of each ten and high for the last four. After a power-on reset or the release of system reset, the slow pulse is forced low for the first full ten seconds. While system reset is active, the output is low in both modes.

When the prescaler is cleared by a seconds adjustment, that clear does not count as a second. The current slow cycle therefore lengthens, and the duty of that one cycle shifts. A secondary chip-select input decides whether the pin is driven or left floating.

Top module: `tpg_top`

## Requirements
- R1: With the select bit at 0, `tp_out` equals prescaler bit `FAST_BIT` in every cycle. This gives a square wave with a 50% low duty: 1024 Hz with the default 15-bit prescaler and bit 4.
- R2: With the select bit at 1, `tp_out` follows a count of second ticks modulo `SLOW_DIV`. It is low for counts 0 to `LOW_TICKS`-1 and high for the remaining counts. A second tick is the step of `presc` from all ones to zero without `presc_clr`.
- R3: After `rst_n` is released, or after `sys_reset` falls, the slow pulse stays low until the tick count has completed one full wrap. With the defaults this is 10 seconds.
- R4: While `sys_reset` is 1, `tp_out` is 0. It also clears the tick count, re-arms the low hold of R3 and returns the select bit to 0 (fast mode).
- R5: The select bit takes the value of `sel_val` only on a clock edge where `sel_load` is 1. The new mode shows at the output from the next cycle. A change of `sel_val` while `sel_load` is 0 has no effect.
- R6: A cycle with `presc_clr` at 1 never produces a second tick, even when `presc` moves from all ones to zero. The slow cycle in progress is stretched by the time the prescaler had already counted.
- R7: `tp_oe` is 1 exactly while `cs_aux` is 1. When `tp_oe` is 0 the pin floats.
- R8: After `rst_n`, the block is in fast mode with a tick count of 0 and the low hold armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the prescaler advances at most once per cycle |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_reset | input | 1 | System reset from the control register, active high |
| presc | input | PRESC_W | Current value of the sub-second prescaler |
| presc_clr | input | 1 | Marks a cycle in which the prescaler is being cleared |
| sel_load | input | 1 | Commit strobe for the select bit (8th serial clock edge) |
| sel_val | input | 1 | New select value: 0 fast square wave, 1 slow 10 s pulse |
| cs_aux | input | 1 | Secondary chip select; 1 lets the pin be driven |
| tp_out | output | 1 | Pulse level for the pin |
| tp_oe | output | 1 | Output enable of the pin driver |

## Verification
The hardest situation to reach is a prescaler clear that lands exactly on the all-ones count. Only there would a missing clear qualification turn the clear into an extra second. The bench drives the prescaler itself with an 8-bit width, so a second is 256 cycles. It clears once mid-second and once exactly at all ones. It then checks the slow level in the middle of each later second against a second count that ignores both clears. The end of the 10-second hold is reached the same way: a system reset realigns the bench's count, and the bench samples every second from 0 to 24.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic {
        TP_FAST = 1'b0,
        TP_SLOW = 1'b1
    } tp_mode_e;
endpackage

// File: rtl/tpg_sec_edge.sv
// Derives the one-second tick from the prescaler wrap (all ones -> zero).
module tpg_sec_edge #(
    parameter int PRESC_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sys_reset,
    input  logic [PRESC_W-1:0] presc,
    input  logic               presc_clr,
    output logic               sec_tick
);
    typedef struct packed {
        logic at_max;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.at_max = (&presc) & ~sys_reset;
        // a clear never counts as a second (R6)
        sec_tick    = st_q.at_max & (presc == '0) & ~presc_clr & ~sys_reset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tpg_decade.sv
// Counts second ticks modulo SLOW_DIV and holds the slow level low
// until the first complete wrap after reset.
module tpg_decade #(
    parameter int SLOW_DIV  = 10,
    parameter int LOW_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_reset,
    input  logic sec_tick,
    output logic slow_level
);
    localparam int CNT_W = $clog2(SLOW_DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_DIV - 1);
    localparam logic [CNT_W-1:0] HIGH_FROM = CNT_W'(LOW_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sys_reset) begin
            st_d.cnt  = '0;
            st_d.hold = 1'b1;
        end else if (sec_tick) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.hold = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        slow_level = ~st_q.hold & (st_q.cnt >= HIGH_FROM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.hold <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.cnt} < (CNT_W+1)'(SLOW_DIV));

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !sys_reset) |=> $stable(st_q.cnt));

    p_hold_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold) |-> (st_q.cnt == '0));

    p_sysrst_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |=> (st_q.hold && st_q.cnt == '0));
endmodule

// File: rtl/tpg_sel_reg.sv
// Select bit, committed only on the load strobe.
module tpg_sel_reg
    import tpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sys_reset,
    input  logic     sel_load,
    input  logic     sel_val,
    output tp_mode_e mode
);
    typedef struct packed {
        tp_mode_e mode;
    } sel_t;

    sel_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sys_reset)     st_d.mode = TP_FAST;
        else if (sel_load) st_d.mode = sel_val ? TP_SLOW : TP_FAST;
        mode = st_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.mode <= TP_FAST;
        else        st_q <= st_d;
    end

    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_load && !sys_reset) |=> $stable(st_q.mode));
endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int PRESC_W   = 15,
    parameter int FAST_BIT  = 4,
    parameter int SLOW_DIV  = 10,
    parameter int LOW_TICKS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sys_reset,
    input  logic [PRESC_W-1:0] presc,
    input  logic               presc_clr,
    input  logic               sel_load,
    input  logic               sel_val,
    input  logic               cs_aux,
    output logic               tp_out,
    output logic               tp_oe
);
    logic     sec_tick;
    logic     slow_level;
    tp_mode_e mode;
    logic     level_d;

    tpg_sec_edge #(.PRESC_W(PRESC_W)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_reset (sys_reset),
        .presc     (presc),
        .presc_clr (presc_clr),
        .sec_tick  (sec_tick)
    );

    tpg_decade #(.SLOW_DIV(SLOW_DIV), .LOW_TICKS(LOW_TICKS)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_reset  (sys_reset),
        .sec_tick   (sec_tick),
        .slow_level (slow_level)
    );

    tpg_sel_reg u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_reset (sys_reset),
        .sel_load  (sel_load),
        .sel_val   (sel_val),
        .mode      (mode)
    );

    // fast mode taps the prescaler directly to stay phase-aligned (R1)
    always_comb begin
        if (sys_reset)             level_d = 1'b0;
        else if (mode == TP_SLOW)  level_d = slow_level;
        else                       level_d = presc[FAST_BIT];
    end

    assign tp_out = level_d;
    assign tp_oe  = cs_aux;

    p_tick_not_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_clr && $past(&presc)) |-> !sec_tick);
endmodule

// File: tb/tb_tpg_top.sv
module tb_tpg_top;
    localparam int PW = 8;
    localparam int FB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sys_reset = 1'b0;
    logic [PW-1:0] presc = '0;
    logic          presc_clr = 1'b0;
    logic          sel_load = 1'b0;
    logic          sel_val = 1'b0;
    logic          cs_aux = 1'b1;
    logic          tp_out, tp_oe;

    int total = 0;
    int bad = 0;
    int secs = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tpg_top #(.PRESC_W(PW), .FAST_BIT(FB), .SLOW_DIV(10), .LOW_TICKS(6)) dut (
        .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .presc(presc),
        .presc_clr(presc_clr), .sel_load(sel_load), .sel_val(sel_val),
        .cs_aux(cs_aux), .tp_out(tp_out), .tp_oe(tp_oe)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance the prescaler by one, just after a rising edge
    task automatic step();
        @(posedge clk);
        #1;
        presc = presc + 1'b1;
        if (presc == '0) secs++;
    endtask

    // prescaler clear: presc goes to 0 with the clear marker, no new second
    task automatic do_clr();
        @(posedge clk);
        #1;
        presc = '0;
        presc_clr = 1'b1;
        @(posedge clk);
        #1;
        presc_clr = 1'b0;
        presc = presc + 1'b1;
    endtask

    task automatic slow_check(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            do step(); while (presc != 8'd128);
            @(negedge clk);
            chk(tp_out, (secs >= 10 && (secs % 10) >= 6) ? 1 : 0, tag);
        end
    endtask

    task automatic fast_window(input int n, input string tag, output int highs);
        int miss = 0;
        highs = 0;
        for (int i = 0; i < n; i++) begin
            step();
            @(negedge clk);
            if (tp_out !== presc[FB]) miss++;
            if (tp_out === 1'b1) highs++;
        end
        chk(miss, 0, tag);
    endtask

    task automatic sys_reset_pulse();
        @(posedge clk);
        #1;
        sys_reset = 1'b1;
        presc = 8'd4;
        secs = 0;
        @(negedge clk);
        chk(tp_out, 0, "R4 output low during system reset");
        @(posedge clk);
        #1;
        presc = '0;
        @(posedge clk);
        #1;
        sys_reset = 1'b0;
    endtask

    task automatic load_slow_at_4();
        do step(); while (presc != 8'd4);
        sel_load = 1'b1;
        sel_val = 1'b1;
        @(negedge clk);
        chk(tp_out, 1, "R5 old mode until strobe edge");
        step();
        sel_load = 1'b0;
        @(negedge clk);
        chk(tp_out, 0, "R5 slow mode after strobe (held low R3)");
    endtask

    task automatic t_reset();
        int h;
        @(negedge clk);
        chk(tp_oe, 1, "R7 oe with cs_aux high");
        fast_window(8, "R8 fast mode after reset", h);
    endtask

    task automatic t_fast();
        int h;
        fast_window(256, "R1 output tracks prescaler bit", h);
        chk(h, 128, "R1 50 percent duty");
    endtask

    task automatic t_ignore_sel();
        int h;
        sel_val = 1'b1;
        fast_window(64, "R5 sel_val ignored without load", h);
        sel_val = 1'b0;
    endtask

    task automatic t_slow();
        sys_reset_pulse();
        load_slow_at_4();
        slow_check(25, "R2/R3 slow pulse level per second");
    endtask

    task automatic t_clear();
        do_clr();
        slow_check(3, "R6 mid-second clear adds no second");
        do step(); while (presc != 8'hFF);
        do_clr();
        slow_check(6, "R6 clear at all ones adds no second");
    endtask

    task automatic t_sysrst();
        int h;
        sys_reset_pulse();
        fast_window(16, "R4 select back to fast after system reset", h);
        load_slow_at_4();
        slow_check(12, "R3 low hold re-armed after system reset");
    endtask

    task automatic t_cs();
        @(posedge clk);
        #1;
        cs_aux = 1'b0;
        @(negedge clk);
        chk(tp_oe, 0, "R7 pin floats with cs_aux low");
        @(posedge clk);
        #1;
        cs_aux = 1'b1;
        @(negedge clk);
        chk(tp_oe, 1, "R7 pin driven with cs_aux high");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_fast();
        t_ignore_sel();
        t_slow();
        t_clear();
        t_sysrst();
        t_cs();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule